// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a circular ring of transmit descriptors kept in host memory on behalf of a DMA engine. Software sets a ring base, aligned to 2 KB, and a 4-bit ring-size code. It then pulses a one-bit transmit-pending command for each packet it posts. The block reads descriptors one at a time through a single-word request/acknowledge memory port. Each descriptor takes 8 bytes: a flags word first, then a buffer address. Bit 31 of the flags word is the ownership flag, where 1 means hardware owns the descriptor. Bits 13:0 give the buffer length in bytes.

For every hardware-owned descriptor, the block offers the buffer address and length to a downstream data mover with a valid/ready handshake. It then writes the flags word back with the ownership bit cleared and steps to the next entry, wrapping at the end of the ring. The walk stops at the first descriptor that software still owns. The block then waits for the next pending command and does not poll the ring. A packet that software has only partly handed over is therefore never consumed.

A walk that consumed at least one descriptor raises a one-cycle all-sent event. A mode input selects when that event fires: as soon as the walk ends, or only once the transmit FIFO reports empty.

Top module: `txr_walker`

## Requirements
- R1: After reset, the following are all low: `tx_pend_o`, `mem_req_o`, `xfer_valid_o` and `all_done_o`. The descriptor index `desc_ptr_o[7:0]` is 0, and `desc_ptr_o[28:8]` equals `ring_base_i`.
- R2: A one-cycle `tx_kick_i` sets `tx_pend_o` on the next edge. The bit clears itself on the edge where a walk starts. A kick that arrives while a walk is running stays pending and starts one further walk after the current walk ends.
- R3: The flags word of entry i is read at byte address `{ring_base_i, i, 3'b000}`. Its buffer address is read at `{ring_base_i, i, 3'b100}`. The walker never touches memory outside the 2 KB window selected by `ring_base_i`.
- R4: A descriptor with flags bit 31 = 0 ends the walk. It causes no handoff and no write, and it leaves the index unchanged.
- R5: For each owned descriptor, `xfer_valid_o` is raised with `xfer_addr_o` equal to the second word and `xfer_len_o` equal to flags bits 13:0. Handoffs keep ring order, and the values stay stable until `xfer_ready_i` is seen.
- R6: After the handoff, the walker writes the flags word back to the flags address. Bit 31 is cleared and every other bit is kept. The index advances only after that write is acknowledged.
- R7: The ring holds (code + 1) × 16 entries for size code `ring_size_i`. The index steps by one and goes from (entries − 1) to 0. A ring whose entries are all owned is consumed once, and the index ends where it started.
- R8: With `done_on_drain_i` = 0, `all_done_o` pulses for exactly one cycle after a walk that consumed at least one descriptor. A walk that consumed nothing produces no pulse.
- R9: With `done_on_drain_i` = 1, the pulse is held back while `fifo_empty_i` is low. It fires once, on the cycle after `fifo_empty_i` is seen high.
- R10: A memory request keeps its address, direction and write data stable until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base_i | input | 21 | Ring base in 2 KB units |
| ring_size_i | input | 4 | Ring size code, entries = (code+1)*16 |
| done_on_drain_i | input | 1 | 1: all-sent event waits for FIFO empty |
| tx_kick_i | input | 1 | Transmit-pending command pulse |
| tx_pend_o | output | 1 | Pending command not yet acted on |
| desc_ptr_o | output | 29 | Descriptor pointer {base, index} in 8-byte units |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| xfer_valid_o | output | 1 | Buffer offered to data mover |
| xfer_ready_i | input | 1 | Data mover accepts buffer |
| xfer_addr_o | output | 32 | Buffer byte address |
| xfer_len_o | output | 14 | Buffer length in bytes |
| fifo_empty_i | input | 1 | Transmit FIFO is empty |
| all_done_o | output | 1 | All-sent event, one cycle |

## Verification
If the ring index were corrupted, the very next flags read would leave the expected address. The bench would see a wrong handoff within one descriptor, and the final pointer would also be wrong. A lost or wrong ownership decision shows at the ports as one of three things: a missing handoff, an extra write-back, or a software-owned flags word that has been overwritten. All three are visible before the walk ends. Errors in the event path show as a pulse count other than 0 or 1 per walk, or as a pulse that arrives while the FIFO is still reported busy. The sweeps cover ring sizes of 16 to 64 entries and the full 256-entry ring, with walks of zero, one, several and all entries.

// File: rtl/txr_pkg.sv
package txr_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FLAGS,
    ST_RD_BUF,
    ST_HAND,
    ST_WRBACK
  } walk_state_t;

  // Number of ring entries for a size code.
  function automatic int unsigned ring_entries(int unsigned code, int unsigned step);
    return (code + 1) * step;
  endfunction

  // Next ring index with wrap-around.
  function automatic int unsigned next_index(int unsigned idx, int unsigned entries);
    return (idx + 1 >= entries) ? 0 : idx + 1;
  endfunction

  // Flags word as returned to software.
  function automatic logic [WORD_W-1:0] drop_owner(logic [WORD_W-1:0] w, int unsigned own_bit);
    logic [WORD_W-1:0] r;
    r = w;
    r[own_bit] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/txr_pend.sv
module txr_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic take_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_o <= 1'b0;
    else if (kick_i) pend_o <= 1'b1;
    else if (take_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/txr_index.sv
module txr_index #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned SZ_W    = 4,
  parameter int unsigned SZ_STEP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [SZ_W-1:0]  size_code_i,
  output logic [IDX_W-1:0] idx_o
);
  import txr_pkg::*;

  int unsigned entries;
  logic [IDX_W-1:0] idx_next;

  always_comb begin
    entries  = ring_entries(int'(size_code_i), SZ_STEP);
    idx_next = IDX_W'(next_index(int'(idx_o), entries));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_o <= '0;
    else if (step_i) idx_o <= idx_next;
  end
endmodule

// File: rtl/txr_seq.sv
module txr_seq #(
  parameter int unsigned BASE_W  = 21,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned OWN_BIT = 31
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pend_i,
  output logic                         take_o,
  input  logic [BASE_W-1:0]            base_i,
  input  logic [IDX_W-1:0]             idx_i,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [BASE_W+IDX_W+2:0]      mem_addr_o,
  output logic [txr_pkg::WORD_W-1:0]   mem_wdata_o,
  input  logic                         mem_ack_i,
  input  logic [txr_pkg::WORD_W-1:0]   mem_rdata_i,
  output logic                         xfer_valid_o,
  input  logic                         xfer_ready_i,
  output logic [txr_pkg::WORD_W-1:0]   xfer_addr_o,
  output logic [LEN_W-1:0]             xfer_len_o,
  output logic                         step_o,
  output logic                         sw_seen_o,
  output logic                         walk_done_o
);
  import txr_pkg::*;

  localparam int unsigned AW = BASE_W + IDX_W + 3;

  walk_state_t st;
  logic [WORD_W-1:0] flags_q;
  logic [WORD_W-1:0] buf_q;
  logic              got_any;
  logic [AW-1:0]     flag_addr;
  logic [AW-1:0]     buf_addr;
  logic              owned;

  always_comb begin
    flag_addr    = {base_i, idx_i, 3'b000};
    buf_addr     = {base_i, idx_i, 3'b100};
    owned        = mem_rdata_i[OWN_BIT];
    mem_req_o    = (st == ST_RD_FLAGS) || (st == ST_RD_BUF) || (st == ST_WRBACK);
    mem_we_o     = (st == ST_WRBACK);
    mem_addr_o   = (st == ST_RD_BUF) ? buf_addr : flag_addr;
    mem_wdata_o  = (st == ST_WRBACK) ? drop_owner(flags_q, OWN_BIT) : '0;
    xfer_valid_o = (st == ST_HAND);
    xfer_addr_o  = buf_q;
    xfer_len_o   = flags_q[LEN_W-1:0];
    take_o       = (st == ST_IDLE) && pend_i;
    step_o       = (st == ST_WRBACK) && mem_ack_i;
    sw_seen_o    = (st == ST_RD_FLAGS) && mem_ack_i && !owned;
    walk_done_o  = sw_seen_o && got_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      flags_q <= '0;
      buf_q   <= '0;
      got_any <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (pend_i) begin
          st      <= ST_RD_FLAGS;
          got_any <= 1'b0;
        end
        ST_RD_FLAGS: if (mem_ack_i) begin
          flags_q <= mem_rdata_i;
          st      <= owned ? ST_RD_BUF : ST_IDLE;
        end
        ST_RD_BUF: if (mem_ack_i) begin
          buf_q <= mem_rdata_i;
          st    <= ST_HAND;
        end
        ST_HAND: if (xfer_ready_i) st <= ST_WRBACK;
        ST_WRBACK: if (mem_ack_i) begin
          got_any <= 1'b1;
          st      <= ST_RD_FLAGS;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_done.sv
module txr_done (
  input  logic clk,
  input  logic rst_n,
  input  logic drain_mode_i,
  input  logic fifo_empty_i,
  input  logic walk_done_i,
  output logic all_done_o
);
  logic armed;
  logic wanted;
  logic fire;

  always_comb begin
    wanted = armed || walk_done_i;
    fire   = wanted && (!drain_mode_i || fifo_empty_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      all_done_o <= 1'b0;
    end else begin
      armed      <= wanted && !fire;
      all_done_o <= fire;
    end
  end
endmodule

// File: rtl/txr_walker.sv
module txr_walker #(
  parameter int unsigned BASE_W  = 21,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned SZ_W    = 4,
  parameter int unsigned SZ_STEP = 16,
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned OWN_BIT = 31
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BASE_W-1:0]           ring_base_i,
  input  logic [SZ_W-1:0]             ring_size_i,
  input  logic                        done_on_drain_i,
  input  logic                        tx_kick_i,
  output logic                        tx_pend_o,
  output logic [BASE_W+IDX_W-1:0]     desc_ptr_o,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [BASE_W+IDX_W+2:0]     mem_addr_o,
  output logic [31:0]                 mem_wdata_o,
  input  logic                        mem_ack_i,
  input  logic [31:0]                 mem_rdata_i,
  output logic                        xfer_valid_o,
  input  logic                        xfer_ready_i,
  output logic [31:0]                 xfer_addr_o,
  output logic [LEN_W-1:0]            xfer_len_o,
  input  logic                        fifo_empty_i,
  output logic                        all_done_o
);
  // Internal events, named for the checker.
  logic             take_evt;
  logic             step_evt;
  logic             sw_seen_evt;
  logic             walk_done_evt;
  logic [IDX_W-1:0] idx;

  txr_pend u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_i (tx_kick_i),
    .take_i (take_evt),
    .pend_o (tx_pend_o)
  );

  txr_index #(.IDX_W(IDX_W), .SZ_W(SZ_W), .SZ_STEP(SZ_STEP)) u_index (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_evt),
    .size_code_i (ring_size_i),
    .idx_o       (idx)
  );

  txr_seq #(.BASE_W(BASE_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .OWN_BIT(OWN_BIT)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_i       (tx_pend_o),
    .take_o       (take_evt),
    .base_i       (ring_base_i),
    .idx_i        (idx),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .xfer_valid_o (xfer_valid_o),
    .xfer_ready_i (xfer_ready_i),
    .xfer_addr_o  (xfer_addr_o),
    .xfer_len_o   (xfer_len_o),
    .step_o       (step_evt),
    .sw_seen_o    (sw_seen_evt),
    .walk_done_o  (walk_done_evt)
  );

  txr_done u_done (
    .clk          (clk),
    .rst_n        (rst_n),
    .drain_mode_i (done_on_drain_i),
    .fifo_empty_i (fifo_empty_i),
    .walk_done_i  (walk_done_evt),
    .all_done_o   (all_done_o)
  );

  assign desc_ptr_o = {ring_base_i, idx};
endmodule

// File: rtl/txr_walker_chk.sv
module txr_walker_chk #(
  parameter int unsigned BASE_W  = 21,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned SZ_W    = 4,
  parameter int unsigned SZ_STEP = 16,
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned OWN_BIT = 31
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [BASE_W-1:0]       ring_base_i,
  input logic [SZ_W-1:0]         ring_size_i,
  input logic                    done_on_drain_i,
  input logic                    tx_pend_o,
  input logic [BASE_W+IDX_W-1:0] desc_ptr_o,
  input logic                    mem_req_o,
  input logic                    mem_we_o,
  input logic [BASE_W+IDX_W+2:0] mem_addr_o,
  input logic [31:0]             mem_wdata_o,
  input logic                    mem_ack_i,
  input logic                    xfer_valid_o,
  input logic                    xfer_ready_i,
  input logic [31:0]             xfer_addr_o,
  input logic [LEN_W-1:0]        xfer_len_o,
  input logic                    fifo_empty_i,
  input logic                    all_done_o,
  input logic                    step_evt,
  input logic                    sw_seen_evt
);
  import txr_pkg::*;

  localparam int unsigned AW = BASE_W + IDX_W + 3;

  logic [IDX_W-1:0] last_idx;
  assign last_idx = IDX_W'(ring_entries(int'(ring_size_i), SZ_STEP) - 1);

  // R2
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_pend_o) |-> mem_req_o);

  // R3
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_addr_o[AW-1:IDX_W+3] == ring_base_i);

  // R4
  sw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_seen_evt |=> !xfer_valid_o && !mem_req_o);

  // R5
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_len_o));

  // R6
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> !mem_wdata_o[OWN_BIT]);

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && desc_ptr_o[IDX_W-1:0] == last_idx |=> desc_ptr_o[IDX_W-1:0] == '0);

  // R7
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && desc_ptr_o[IDX_W-1:0] != last_idx |=>
      desc_ptr_o[IDX_W-1:0] == IDX_W'($past(desc_ptr_o[IDX_W-1:0]) + 1'b1));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_done_o |=> !all_done_o);

  // R9
  drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_done_o && $past(done_on_drain_i) |-> $past(fifo_empty_i));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));
endmodule

bind txr_walker txr_walker_chk #(
  .BASE_W(BASE_W), .IDX_W(IDX_W), .SZ_W(SZ_W), .SZ_STEP(SZ_STEP), .LEN_W(LEN_W), .OWN_BIT(OWN_BIT)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ring_base_i     (ring_base_i),
  .ring_size_i     (ring_size_i),
  .done_on_drain_i (done_on_drain_i),
  .tx_pend_o       (tx_pend_o),
  .desc_ptr_o      (desc_ptr_o),
  .mem_req_o       (mem_req_o),
  .mem_we_o        (mem_we_o),
  .mem_addr_o      (mem_addr_o),
  .mem_wdata_o     (mem_wdata_o),
  .mem_ack_i       (mem_ack_i),
  .xfer_valid_o    (xfer_valid_o),
  .xfer_ready_i    (xfer_ready_i),
  .xfer_addr_o     (xfer_addr_o),
  .xfer_len_o      (xfer_len_o),
  .fifo_empty_i    (fifo_empty_i),
  .all_done_o      (all_done_o),
  .step_evt        (step_evt),
  .sw_seen_evt     (sw_seen_evt)
);

// File: tb/test_txr_walker.sv
module test_txr_walker;
  localparam logic [20:0] BASE = 21'h0000A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] ring_base_i = BASE;
  logic [3:0]  ring_size_i = 4'd0;
  logic        done_on_drain_i = 1'b0;
  logic        tx_kick_i = 1'b0;
  logic        tx_pend_o;
  logic [28:0] desc_ptr_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        xfer_valid_o;
  logic        xfer_ready_i = 1'b0;
  logic [31:0] xfer_addr_o;
  logic [13:0] xfer_len_o;
  logic        fifo_empty_i = 1'b1;
  logic        all_done_o;

  txr_walker i_txr_walker (.*);

  always #4 clk = ~clk;

  int unsigned n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:511];
  int unsigned mem_lat = 0, wcnt = 0, wr_cnt = 0, rd_cnt = 0, bad_addr = 0;
  bit          stall = 0;
  int unsigned cyc = 0;
  logic [31:0] xa [0:4095];
  logic [13:0] xl [0:4095];
  int unsigned xn = 0, done_cnt = 0;
  int unsigned cur = 0;
  int unsigned walk_no = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory responder (R3: window, R10 covered by checker)
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mem_ack_i = 1'b0;
      wcnt = 0;
    end else if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt >= mem_lat) begin
        if (mem_addr_o[31:11] != BASE) bad_addr++;
        if (mem_we_o) begin
          mem[mem_addr_o[10:2]] = mem_wdata_o;
          wr_cnt++;
        end else begin
          mem_rdata_i = mem[mem_addr_o[10:2]];
          rd_cnt++;
        end
        mem_ack_i = 1'b1;
      end else wcnt++;
    end
  end

  // Data mover model and event counter
  always @(negedge clk) begin
    xfer_ready_i = !stall || (cyc % 3 == 0);
    if (rst_n && xfer_valid_o && xfer_ready_i) begin
      xa[xn % 4096] = xfer_addr_o;
      xl[xn % 4096] = xfer_len_o;
      xn++;
    end
    if (rst_n && all_done_o) done_cnt++;
  end

  function automatic logic [31:0] exp_flags(int unsigned i, int unsigned k);
    return 32'h8000_0000 | ((i & 32'h1f) << 16) | ((i * 37 + k * 11 + 1) & 32'h3fff);
  endfunction
  function automatic logic [31:0] exp_buf(int unsigned i, int unsigned k);
    return 32'h4000_0000 + i * 256 + k;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur = 0;
    // R1
    check("R1 pend", tx_pend_o, 0);
    check("R1 req", mem_req_o, 0);
    check("R1 xfer", xfer_valid_o, 0);
    check("R1 done", all_done_o, 0);
    check("R1 ptr", desc_ptr_o, {BASE, 8'h00});
  endtask

  task automatic kick();
    @(negedge clk);
    tx_kick_i = 1'b1;
    @(negedge clk);
    tx_kick_i = 1'b0;
    check("R2 pend set", tx_pend_o, 1);
    @(negedge clk);
    check("R2 pend self-clear", tx_pend_o, 0);
  endtask

  task automatic wait_idle();
    int unsigned q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (!tx_pend_o && !mem_req_o && !xfer_valid_o && !mem_ack_i) q++;
      else q = 0;
    end
  endtask

  task automatic fill(input int unsigned e, input int unsigned n, input int unsigned k);
    for (int j = 0; j < e; j++) begin
      int unsigned id = (cur + j) % e;
      if (j < n) begin
        mem[2*id]   = exp_flags(id, k);
        mem[2*id+1] = exp_buf(id, k);
      end else begin
        mem[2*id]   = 32'h0000_0055;
        mem[2*id+1] = 32'hdead_0000;
      end
    end
  endtask

  task automatic run_walk(input int unsigned n);
    int unsigned e = (ring_size_i + 1) * 16;
    int unsigned k = walk_no++;
    int unsigned x0, w0, d0, b0;
    fill(e, n, k);
    x0 = xn; w0 = wr_cnt; d0 = done_cnt; b0 = bad_addr;
    kick();
    wait_idle();
    check("R5 handoff count", xn - x0, n);
    check("R4 write count", wr_cnt - w0, n);
    check("R3 window", bad_addr - b0, 0);
    for (int j = 0; j < n; j++) begin
      int unsigned id = (cur + j) % e;
      check("R5 addr", xa[(x0 + j) % 4096], exp_buf(id, k));
      check("R5 len", xl[(x0 + j) % 4096], exp_flags(id, k) & 32'h3fff);
      check("R6 writeback", mem[2*id], exp_flags(id, k) & 32'h7fff_ffff);
    end
    if (n < e) check("R4 sw flags untouched", mem[2*((cur + n) % e)], 32'h55);
    check("R8 done count", done_cnt - d0, (n > 0) ? 1 : 0);
    cur = (cur + n) % e;
    check("R7 index", desc_ptr_o[7:0], cur);
    check("R3 base", desc_ptr_o[28:8], BASE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // Sweep ring sizes and walk lengths (R3-R8)
    for (int c = 0; c < 4; c++) begin
      int unsigned e = (c + 1) * 16;
      ring_size_i = 4'(c);
      mem_lat = c % 3;
      stall = c[0];
      do_reset();
      run_walk(0);
      run_walk(1);
      run_walk(3);
      run_walk(e - 1);
      run_walk(5);
      run_walk(e);
      run_walk(e - 2);
    end
    // Full 256-entry ring (R7)
    ring_size_i = 4'd15;
    mem_lat = 1;
    stall = 0;
    do_reset();
    run_walk(200);
    run_walk(256);
    // Drain mode with FIFO already empty (R9)
    done_on_drain_i = 1'b1;
    run_walk(4);

    // Drain mode, FIFO busy (R9)
    ring_size_i = 4'd0;
    mem_lat = 0;
    do_reset();
    fifo_empty_i = 1'b0;
    begin
      int unsigned d0;
      fill(16, 3, 99);
      d0 = done_cnt;
      kick();
      wait_idle();
      repeat (10) @(negedge clk);
      check("R9 held while FIFO busy", done_cnt - d0, 0);
      fifo_empty_i = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 fires after drain", done_cnt - d0, 1);
      repeat (5) @(negedge clk);
      check("R9 single pulse", done_cnt - d0, 1);
      cur = 3;
    end

    // Kick while busy (R2)
    done_on_drain_i = 1'b0;
    stall = 1;
    begin
      int unsigned x0, r0, d0;
      fill(16, 4, 7);
      x0 = xn; r0 = rd_cnt; d0 = done_cnt;
      kick();
      while (xn == x0) @(negedge clk);
      tx_kick_i = 1'b1;
      @(negedge clk);
      tx_kick_i = 1'b0;
      check("R2 pend held while busy", tx_pend_o, 1);
      wait_idle();
      check("R2 second walk reads", rd_cnt - r0, 4 * 2 + 2);
      check("R2 handoffs", xn - x0, 4);
      check("R8 empty rewalk no pulse", done_cnt - d0, 1);
      check("R2 pend clear", tx_pend_o, 0);
      check("R7 index", desc_ptr_o[7:0], 7);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule